// File: doc/BRIEF.md
# Per-Color Black Level Calibrator

This block keeps one signed black-level offset for each of the four positions of a 2x2 Bayer mosaic and steers those offsets so that dark pixels read at a programmable target level. It watches the pixel stream, takes only samples flagged as coming from the optically dark rows, and sorts them by color from the row and column parity bits. The four offsets leave the block as one packed vector for the analog offset stage. They can also be read one at a time through a host read port.

Two update modes are used. In tracking mode, each color averages a fixed window of dark samples over a frame. At the next frame start the offset moves by a fraction of the error between the target and that average. After a configuration change, or on a manual request, the next frame runs in sweep mode instead. In sweep mode every small group of same-color dark samples moves the offset by the full error, so several trial offsets are applied within one dark period. The offset left at the end of the sweep becomes the starting point for later tracking.

A host override bit freezes the automatic logic. While it is set, the host writes the offsets directly.

Top module: `blc_calibrator`

## Requirements
- R1: After reset all four offsets read 0, and the first frame after reset runs in sweep mode.
- R2: The color index is {row parity, column parity}. The offset of color k sits in bits [9k+8:9k] of `offset_out`, and `host_rdata` returns the offset of the color selected by `host_rsel`.
- R3: In tracking mode each color sums its first 16 dark samples of the frame, and any later samples of that color are ignored. At the next `frame_start` edge the offset becomes sat(offset + floor((64 - floor(sum/16))/4)), visible from the cycle after that edge.
- R4: A color that collected fewer than 16 dark samples in a tracking frame keeps its offset at the next frame start.
- R5: In sweep mode, every group of 8 same-color dark samples sets that offset to sat(offset + 64 - floor(sum/8)). The new value appears on the second rising edge, counting from the edge that captures the eighth sample. Sweep mode never changes offsets at frame start.
- R6: A sweep request only arms the sweep, and the sweep begins at the next `frame_start`. It lasts exactly that one frame unless the block is armed again, and `frame_start` clears the armed state.
- R7: While `ctl_sweep_off` is 1, `cfg_change` does not arm a sweep, but `ctl_sweep_go` still does.
- R8: While `ctl_override` is 1, automatic updates stop. A `host_wr` then loads `host_wdata` into the offset selected by `host_sel` on that edge. While `ctl_override` is 0, `host_wr` has no effect.
- R9: Samples that are not valid, not dark, or presented in the same cycle as `frame_start` are not counted.
- R10: Every offset saturates at the 9-bit signed limits of -256 and +255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel sample present this cycle |
| pix_dark | input | 1 | Sample comes from a dark row |
| pix_row_odd | input | 1 | Row parity of the sample |
| pix_col_odd | input | 1 | Column parity of the sample |
| pix_data | input | 10 | Unsigned sample value |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| cfg_change | input | 1 | Strobe: sensor configuration was changed |
| ctl_override | input | 1 | Host owns the offsets |
| ctl_sweep_off | input | 1 | Block sweep arming by configuration changes |
| ctl_sweep_go | input | 1 | Strobe: arm a sweep manually |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Color index for the host write |
| host_wdata | input | 9 | Signed value for the host write |
| host_rsel | input | 2 | Color index for the host read |
| host_rdata | output | 9 | Offset of the selected color |
| offset_out | output | 36 | All four signed offsets, packed |

## Verification
The bench builds the block with its defaults: 10-bit samples, 9-bit offsets, a target of 64, a 16-sample tracking window, 8-sample sweep groups and a gain shift of 2. With these values a single sweep group of full-scale samples drives an offset past the negative limit. Four all-zero groups climb through +255, so both saturation limits are reached within a few hundred cycles. The small window sizes also let each frame be built sample by sample. The bench places partial windows, samples past the window, samples on the frame-start cycle and ignored host writes exactly where the reference model expects them.

// File: rtl/blc_pkg.sv
package blc_pkg;
   localparam int NUM_COLORS = 4;
   localparam int COL_W      = 2;

   typedef enum logic {
      MODE_TRACK = 1'b0,
      MODE_SWEEP = 1'b1
   } blc_mode_e;
endpackage

// File: rtl/blc_accum.sv
// Per-color sample accumulator: a fixed tracking window, or repeating sweep groups.
module blc_accum #(
   parameter int DATA_W  = 10,
   parameter int NORM_LG = 4,
   parameter int SWP_LG  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              smp,
   input  logic              sweep,
   input  logic [DATA_W-1:0] data,
   output logic              trk_full,
   output logic [DATA_W-1:0] trk_avg,
   output logic              swp_hit,
   output logic [DATA_W-1:0] swp_avg
);
   localparam int SUM_W = DATA_W + NORM_LG;
   localparam int CNT_W = NORM_LG + 1;
   localparam logic [CNT_W-1:0] TRK_N    = CNT_W'(1 << NORM_LG);
   localparam logic [CNT_W-1:0] SWP_LAST = CNT_W'((1 << SWP_LG) - 1);

   logic [SUM_W-1:0] sum_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] sum_inc;
   logic             hit_q;
   logic [DATA_W-1:0] havg_q;

   assign sum_inc = sum_q + SUM_W'(data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q  <= '0;
         cnt_q  <= '0;
         hit_q  <= 1'b0;
         havg_q <= '0;
      end else begin
         hit_q <= 1'b0;
         if (clr) begin
            sum_q <= '0;
            cnt_q <= '0;
         end else if (smp) begin
            if (sweep) begin
               if (cnt_q == SWP_LAST) begin
                  sum_q  <= '0;
                  cnt_q  <= '0;
                  hit_q  <= 1'b1;
                  havg_q <= DATA_W'(sum_inc >> SWP_LG);
               end else begin
                  sum_q <= sum_inc;
                  cnt_q <= cnt_q + 1'b1;
               end
            end else if (cnt_q != TRK_N) begin
               sum_q <= sum_inc;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign trk_full = (cnt_q == TRK_N);
   assign trk_avg  = sum_q[SUM_W-1:NORM_LG];
   assign swp_hit  = hit_q;
   assign swp_avg  = havg_q;
endmodule

// File: rtl/blc_mode_ctrl.sv
// Arms a sweep on request and switches mode on frame boundaries.
module blc_mode_ctrl
   import blc_pkg::*;
#(
   parameter bit ARM_AT_RESET = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_start,
   input  logic      cfg_change,
   input  logic      sweep_off,
   input  logic      sweep_go,
   output logic      armed,
   output blc_mode_e mode
);
   logic req;
   assign req = (cfg_change & ~sweep_off) | sweep_go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= ARM_AT_RESET;
         mode  <= MODE_TRACK;
      end else if (frame_start) begin
         mode  <= armed ? MODE_SWEEP : MODE_TRACK;
         armed <= req;
      end else begin
         armed <= armed | req;
      end
   end
endmodule

// File: rtl/blc_offset_slot.sv
// One color's offset register: saturating error step or host load.
module blc_offset_slot #(
   parameter int DATA_W     = 10,
   parameter int OFF_W      = 9,
   parameter int GAIN_SHIFT = 2,
   parameter int TARGET     = 64,
   parameter int OFF_INIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              override,
   input  logic              host_wr,
   input  logic [OFF_W-1:0]  host_data,
   input  logic              trk_go,
   input  logic [DATA_W-1:0] trk_avg,
   input  logic              swp_go,
   input  logic [DATA_W-1:0] swp_avg,
   output logic [OFF_W-1:0]  off_q
);
   localparam int ERR_W = DATA_W + 2;
   localparam int ADD_W = ((OFF_W > ERR_W) ? OFF_W : ERR_W) + 1;
   localparam logic signed [ERR_W-1:0] TGT   = ERR_W'(TARGET);
   localparam logic signed [ADD_W-1:0] MAX_V = ADD_W'((2 ** (OFF_W - 1)) - 1);
   localparam logic signed [ADD_W-1:0] MIN_V = ~MAX_V;

   logic signed [ERR_W-1:0] trk_err, swp_err, trk_step, step;
   logic signed [ADD_W-1:0] raw;
   logic [OFF_W-1:0]        sat;

   assign trk_err = TGT - $signed({2'b00, trk_avg});
   assign swp_err = TGT - $signed({2'b00, swp_avg});

   generate
      if (GAIN_SHIFT == 0) begin : g_unity
         assign trk_step = trk_err;
      end else begin : g_shift
         assign trk_step = trk_err >>> GAIN_SHIFT;
      end
   endgenerate

   assign step = swp_go ? swp_err : trk_step;
   assign raw  = ADD_W'($signed(off_q)) + ADD_W'(step);

   always_comb begin
      if (raw > MAX_V)      sat = MAX_V[OFF_W-1:0];
      else if (raw < MIN_V) sat = MIN_V[OFF_W-1:0];
      else                  sat = raw[OFF_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q <= OFF_W'(OFF_INIT);
      end else if (override) begin
         if (host_wr) off_q <= host_data;
      end else if (swp_go || trk_go) begin
         off_q <= sat;
      end
   end
endmodule

// File: rtl/blc_calibrator.sv
module blc_calibrator
   import blc_pkg::*;
#(
   parameter int DATA_W       = 10,
   parameter int OFF_W        = 9,
   parameter int NORM_LG      = 4,
   parameter int SWP_LG       = 3,
   parameter int GAIN_SHIFT   = 2,
   parameter int TARGET       = 64,
   parameter int OFF_INIT     = 0,
   parameter bit ARM_AT_RESET = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pix_valid,
   input  logic                        pix_dark,
   input  logic                        pix_row_odd,
   input  logic                        pix_col_odd,
   input  logic [DATA_W-1:0]           pix_data,
   input  logic                        frame_start,
   input  logic                        cfg_change,
   input  logic                        ctl_override,
   input  logic                        ctl_sweep_off,
   input  logic                        ctl_sweep_go,
   input  logic                        host_wr,
   input  logic [COL_W-1:0]            host_sel,
   input  logic [OFF_W-1:0]            host_wdata,
   input  logic [COL_W-1:0]            host_rsel,
   output logic [OFF_W-1:0]            host_rdata,
   output logic [NUM_COLORS*OFF_W-1:0] offset_out
);
   generate
      if (OFF_W < 2) begin : g_bad_off
         $error("OFF_W must be at least 2");
      end
      if (SWP_LG < 1 || SWP_LG > NORM_LG) begin : g_bad_grp
         $error("SWP_LG must lie in 1..NORM_LG");
      end
      if (TARGET < 0 || TARGET >= (2 ** DATA_W)) begin : g_bad_tgt
         $error("TARGET must fit the sample range");
      end
      if (GAIN_SHIFT < 0 || GAIN_SHIFT > DATA_W) begin : g_bad_gain
         $error("GAIN_SHIFT out of range");
      end
   endgenerate

   blc_mode_e        mode;
   logic             armed;
   logic             sweep_on;
   logic [COL_W-1:0] color;
   logic [OFF_W-1:0] off_arr [NUM_COLORS];

   assign sweep_on = (mode == MODE_SWEEP);
   assign color    = {pix_row_odd, pix_col_odd};

   blc_mode_ctrl #(.ARM_AT_RESET(ARM_AT_RESET)) u_mode (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .cfg_change(cfg_change), .sweep_off(ctl_sweep_off),
      .sweep_go(ctl_sweep_go), .armed(armed), .mode(mode)
   );

   generate
      for (genvar k = 0; k < NUM_COLORS; k++) begin : g_color
         logic              smp, full, hit;
         logic [DATA_W-1:0] tavg, savg;

         assign smp = pix_valid & pix_dark & ~frame_start & (color == COL_W'(k));

         blc_accum #(.DATA_W(DATA_W), .NORM_LG(NORM_LG), .SWP_LG(SWP_LG)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr(frame_start), .smp(smp),
            .sweep(sweep_on), .data(pix_data), .trk_full(full),
            .trk_avg(tavg), .swp_hit(hit), .swp_avg(savg)
         );

         blc_offset_slot #(
            .DATA_W(DATA_W), .OFF_W(OFF_W), .GAIN_SHIFT(GAIN_SHIFT),
            .TARGET(TARGET), .OFF_INIT(OFF_INIT)
         ) u_slot (
            .clk(clk), .rst_n(rst_n), .override(ctl_override),
            .host_wr(host_wr && (host_sel == COL_W'(k))),
            .host_data(host_wdata),
            .trk_go(frame_start && !sweep_on && full),
            .trk_avg(tavg), .swp_go(hit), .swp_avg(savg),
            .off_q(off_arr[k])
         );

         assign offset_out[k*OFF_W +: OFF_W] = off_arr[k];
      end
   endgenerate

   assign host_rdata = off_arr[host_rsel];
endmodule

// File: rtl/blc_checker.sv
module blc_checker #(
   parameter int OFF_W = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_start,
   input logic               cfg_change,
   input logic               ctl_sweep_off,
   input logic               ctl_sweep_go,
   input logic               ctl_override,
   input logic               host_wr,
   input logic [1:0]         host_sel,
   input logic [OFF_W-1:0]   host_wdata,
   input logic [4*OFF_W-1:0] offset_out,
   input logic               armed,
   input logic               sweep_on
);
   logic [OFF_W-1:0] offs [4];
   logic [1:0]       sel_d;

   for (genvar k = 0; k < 4; k++) begin : g_unpack
      assign offs[k] = offset_out[k*OFF_W +: OFF_W];
   end

   always_ff @(posedge clk) sel_d <= host_sel;

   assert_override_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_override && !host_wr) |=> $stable(offset_out));

   assert_host_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_override && host_wr) |=> (offs[sel_d] == $past(host_wdata)));

   assert_sweep_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sweep_on) |-> $past(frame_start));

   assert_unarmed_no_sweep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !armed) |=> !sweep_on);

   assert_frame_clears_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !cfg_change && !ctl_sweep_go) |=> !armed);

   assert_blocked_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_change && ctl_sweep_off && !ctl_sweep_go && !armed && !frame_start) |=> !armed);
endmodule

bind blc_calibrator blc_checker #(.OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
   .cfg_change(cfg_change), .ctl_sweep_off(ctl_sweep_off),
   .ctl_sweep_go(ctl_sweep_go), .ctl_override(ctl_override),
   .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
   .offset_out(offset_out), .armed(armed), .sweep_on(sweep_on)
);

// File: tb/blc_calibrator_tb.sv
`timescale 1ns/1ps
module blc_calibrator_tb;
   localparam int TGT = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pix_valid = 0, pix_dark = 0, pix_row_odd = 0, pix_col_odd = 0;
   logic [9:0] pix_data = '0;
   logic       frame_start = 0, cfg_change = 0, ctl_override = 0;
   logic       ctl_sweep_off = 0, ctl_sweep_go = 0, host_wr = 0;
   logic [1:0] host_sel = '0, host_rsel = '0;
   logic [8:0] host_wdata = '0;
   logic [8:0] host_rdata;
   logic [35:0] offset_out;

   int errors = 0, checks = 0, cycles = 0;
   bit done = 0;

   blc_calibrator u_dut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_dark(pix_dark),
      .pix_row_odd(pix_row_odd), .pix_col_odd(pix_col_odd), .pix_data(pix_data),
      .frame_start(frame_start), .cfg_change(cfg_change),
      .ctl_override(ctl_override), .ctl_sweep_off(ctl_sweep_off),
      .ctl_sweep_go(ctl_sweep_go), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
      .offset_out(offset_out)
   );

   always #2.5 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   int moff[4], msum[4], mcnt[4], mpavg[4];
   bit mpend[4];
   bit marmed, msweep;
   int noff[4], nsum[4], ncnt[4], npavg[4];
   bit npend[4];
   int c;
   bit smp, req;

   function automatic int sat9(int v);
      if (v > 255) return 255;
      if (v < -256) return -256;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 4; k++) begin
            moff[k] = 0; msum[k] = 0; mcnt[k] = 0; mpend[k] = 0; mpavg[k] = 0;
         end
         marmed = 1; msweep = 0;
      end else begin
         c   = pix_row_odd * 2 + pix_col_odd;
         smp = pix_valid && pix_dark && !frame_start;
         req = (cfg_change && !ctl_sweep_off) || ctl_sweep_go;
         for (int k = 0; k < 4; k++) begin
            noff[k] = moff[k];
            if (ctl_override) begin
               if (host_wr && host_sel == k) noff[k] = $signed(host_wdata);
            end else if (mpend[k]) begin
               noff[k] = sat9(moff[k] + TGT - mpavg[k]);
            end else if (frame_start && !msweep && mcnt[k] == 16) begin
               noff[k] = sat9(moff[k] + ((TGT - msum[k] / 16) >>> 2));
            end
            npend[k] = 0; npavg[k] = mpavg[k];
            if (msweep && smp && c == k && mcnt[k] == 7) begin
               npend[k] = 1; npavg[k] = (msum[k] + pix_data) / 8;
            end
            nsum[k] = msum[k]; ncnt[k] = mcnt[k];
            if (frame_start) begin
               nsum[k] = 0; ncnt[k] = 0;
            end else if (smp && c == k) begin
               if (msweep) begin
                  if (mcnt[k] == 7) begin nsum[k] = 0; ncnt[k] = 0; end
                  else begin nsum[k] = msum[k] + pix_data; ncnt[k] = mcnt[k] + 1; end
               end else if (mcnt[k] < 16) begin
                  nsum[k] = msum[k] + pix_data; ncnt[k] = mcnt[k] + 1;
               end
            end
         end
         if (frame_start) begin msweep = marmed; marmed = req; end
         else marmed = marmed || req;
         for (int k = 0; k < 4; k++) begin
            moff[k] = noff[k]; msum[k] = nsum[k]; mcnt[k] = ncnt[k];
            mpend[k] = npend[k]; mpavg[k] = npavg[k];
         end
      end
   end

   // Compare every cycle, away from the active edge (R3 model match)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int k = 0; k < 4; k++) begin
            checks++;
            if ($signed(offset_out[k*9 +: 9]) != moff[k]) begin
               errors++;
               $display("FAIL R3 model color %0d: actual=%0d expected=%0d", k,
                        $signed(offset_out[k*9 +: 9]), moff[k]);
            end
         end
         checks++;
         if ($signed(host_rdata) != moff[host_rsel]) begin
            errors++;
            $display("FAIL R2 readback model: actual=%0d expected=%0d",
                     $signed(host_rdata), moff[host_rsel]);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step1();
      @(negedge clk); #1;
      pix_valid = 0; pix_dark = 0; frame_start = 0; cfg_change = 0;
      ctl_sweep_go = 0; host_wr = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step1();
   endtask

   task automatic px(int col, bit dark, int val);
      pix_valid = 1; pix_dark = dark; pix_row_odd = col[1]; pix_col_odd = col[0];
      pix_data = 10'(val);
      step1();
   endtask

   task automatic pxn(int col, int val, int n);
      for (int i = 0; i < n; i++) px(col, 1, val);
   endtask

   task automatic fs();
      frame_start = 1; step1();
   endtask

   task automatic hw(int sel, int val);
      host_wr = 1; host_sel = 2'(sel); host_wdata = 9'(val); step1();
   endtask

   task automatic chk(int k, int exp, string tag);
      checks++;
      if ($signed(offset_out[k*9 +: 9]) != exp) begin
         errors++;
         $display("FAIL %s color %0d: actual=%0d expected=%0d", tag, k,
                  $signed(offset_out[k*9 +: 9]), exp);
      end
      host_rsel = 2'(k); #1;
      checks++;
      if ($signed(host_rdata) != exp) begin
         errors++;
         $display("FAIL R2 readback color %0d: actual=%0d expected=%0d", k,
                  $signed(host_rdata), exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      step1();
      // R1: reset state
      for (int k = 0; k < 4; k++) chk(k, 0, "R1");

      // Frame A: sweep from reset (R1, R5, R9)
      fs();
      for (int i = 0; i < 8; i++) begin
         px(0, 0, 0);        // non-dark, ignored (R9)
         px(0, 1, 100);
      end
      idle(2);
      chk(0, -36, "R5");
      pxn(3, 10, 8);
      idle(2);
      chk(3, 54, "R5");

      // Frame B: tracking (R3, R4, R6)
      fs();
      pxn(0, 80, 8);
      idle(2);
      chk(0, -36, "R6");
      pxn(0, 80, 8);
      pxn(1, 500, 10);
      pxn(2, 0, 16);
      pxn(2, 1023, 4);      // past the window, ignored (R3)
      idle(2);
      chk(0, -36, "R3");

      // Frame C
      frame_start = 1; pix_valid = 1; pix_dark = 1;
      pix_row_odd = 1; pix_col_odd = 1; pix_data = 10'd0;
      step1();              // sample on frame_start cycle dropped (R9)
      idle(1);
      chk(0, -40, "R3");
      chk(1, 0, "R4");
      chk(2, 16, "R3");
      pxn(3, 0, 15);
      ctl_sweep_off = 1;
      cfg_change = 1; step1();

      // Frame D: tracking, sweep was blocked (R7)
      fs();
      idle(1);
      chk(3, 54, "R9");
      pxn(2, 200, 8);
      idle(2);
      chk(2, 16, "R7");
      pxn(2, 200, 8);
      ctl_sweep_go = 1; step1();

      // Frame E: manual sweep (R7, R5, R10)
      fs();
      ctl_sweep_off = 0;
      idle(1);
      chk(2, -18, "R3");
      pxn(2, 0, 8);
      idle(2);
      chk(2, 46, "R5");
      pxn(1, 1023, 8);
      idle(2);
      chk(1, -256, "R10");
      pxn(3, 0, 32);
      idle(2);
      chk(3, 255, "R10");
      cfg_change = 1; step1();

      // Frame F: sweep again, override (R6, R8)
      fs();
      idle(1);
      chk(0, -40, "R6");
      ctl_override = 1;
      pxn(0, 1023, 8);
      idle(2);
      chk(0, -40, "R8");
      hw(2, -100);
      idle(1);
      chk(2, -100, "R8");
      hw(0, 255);
      ctl_override = 0;
      hw(1, 5);
      idle(1);
      chk(1, -256, "R8");
      pxn(0, 0, 8);
      idle(2);
      chk(0, 255, "R10");
      chk(3, 255, "R2");

      idle(3);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule